// File: doc/BRIEF.md
# Write-Protected Clock-Monitor Control Register

This block is a small peripheral on a synchronous byte-wide register bus. It holds a clock-monitor control register that ordinary writes cannot change. To change it, software first writes any value, as a full byte, to a separate unlock register. Only the bus write that comes directly after that unlock write is allowed to reach the protected register.

The protected register carries one sticky enable bit. Once set, only reset clears it. Setting it does not start monitoring. A start bit in a third register must then be written to 1 while enable is already 1. When both bits are set, the monitor-active output goes high and stays high until reset.

Every write to the protected register that the gate blocks produces a one-cycle reject pulse.

Top module: `wprot_ctl`

## Requirements
- R1: After reset the protected register and the start register read 0x00, the gate is disarmed, and `mon_active` and `wr_reject` are 0.
- R2: A write with `wr_byte`=1 to the unlock address (default 0xFFFF_FCB2) arms the gate, whatever the data. If the next write goes to the protected address (default 0xFFFF_F878), it is applied: a 1 in data bit 0 sets the enable bit (register bit 0).
- R3: Once the enable bit is 1, no write clears it, including a write of 0 through an unlocked access. Only reset clears it.
- R4: Bits 7 to 1 of the protected register and of the start register always read 0, whatever data is written.
- R5: A write to the protected address while the gate is disarmed changes nothing. In the cycle after that write, `wr_reject` is 1 for exactly one cycle. An accepted write gives `wr_reject`=0.
- R6: The gate is consumed by the next write, whatever its address. A write to any address other than the unlock address disarms the gate, and a further qualifying unlock write re-arms it. Reads do not change the armed state.
- R7: An unlock-address write with `wr_byte`=0 does not arm the gate, and it disarms the gate if it was armed.
- R8: Reading the unlock address returns 0x00.
- R9: The start register (default 0xFFFF_F87A) holds the start bit at bit 0, and writing it needs no unlock. A 1 in data bit 0 sets the start bit only if enable is already 1. Otherwise the write is ignored. Once set, the start bit stays set until reset.
- R10: `mon_active` is 1 exactly when enable and start are both 1. Once high, it stays high until reset.
- R11: `rdata` is combinational. It shows the addressed register while `rd_en` is 1, and it is 0x00 when `rd_en` is 0 or the address is unmapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Bus address |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_byte | input | 1 | Write covers the full byte (1) or is a partial-unit write (0) |
| wdata | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Read data (combinational) |
| mon_active | output | 1 | Clock monitoring is running |
| wr_reject | output | 1 | One-cycle pulse after a blocked write to the protected register |

## Verification
A read and a write can fall in the same cycle. The case that matters is reading the protected register in the same cycle as the write that uses up the unlock. The bench provokes it with random mixes of reads, unlock writes and writes to every address, some of them back to back. A read is judged against a model that gives the value before the write, and the armed state is judged by whether a later write to the protected register is rejected. A write that disarms the gate immediately followed by a blocked protected write is also provoked, and the reject pulse is checked in the cycle after each of those writes.

// File: rtl/wprot_ctl.sv
module wprot_ctl #(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] PROT_ADDR  = 32'hFFFF_F878,
  parameter logic [ADDR_W-1:0] START_ADDR = 32'hFFFF_F87A,
  parameter logic [ADDR_W-1:0] UNLK_ADDR  = 32'hFFFF_FCB2,
  parameter logic [7:0] PROT_MASK  = 8'h01,
  parameter logic [7:0] START_MASK = 8'h01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              wr_byte,
  input  logic [7:0]        wdata,
  input  logic              rd_en,
  output logic [7:0]        rdata,
  output logic              mon_active,
  output logic              wr_reject
);

  logic [7:0] prot_q, start_q;
  logic       armed_q;

  wire hit_prot  = addr == PROT_ADDR;
  wire hit_start = addr == START_ADDR;
  wire hit_unlk  = addr == UNLK_ADDR;
  wire en        = prot_q[0];
  wire prot_ok   = wr_en && hit_prot && armed_q;
  wire prot_bad  = wr_en && hit_prot && !armed_q;
  wire start_ok  = wr_en && hit_start && en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prot_q    <= 8'h00;
      start_q   <= 8'h00;
      armed_q   <= 1'b0;
      wr_reject <= 1'b0;
    end else begin
      wr_reject <= prot_bad;
      if (wr_en) armed_q <= hit_unlk && wr_byte;
      if (prot_ok) prot_q <= prot_q | (wdata & PROT_MASK);
      if (start_ok) start_q <= start_q | (wdata & START_MASK);
    end
  end

  assign mon_active = en & start_q[0];

  always_comb begin
    rdata = 8'h00;
    if (rd_en) begin
      if (hit_prot) rdata = prot_q;
      else if (hit_start) rdata = start_q;
    end
  end

  a_r3_enable_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> en);
  a_r10_active_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    mon_active |=> mon_active);
  a_r9_start_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    start_q[0] |-> en);
  a_r2_unlocked_set: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && wr_en && hit_prot && wdata[0]) |=> en);
  a_r6_disarm: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !hit_unlk) |=> !armed_q);
  a_r5_blocked_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit_prot && !armed_q) |=> ($stable(prot_q) && wr_reject));

endmodule

// File: tb/test_wprot_ctl.sv
module test_wprot_ctl;
  localparam logic [31:0] PA = 32'hFFFF_F878;
  localparam logic [31:0] SA = 32'hFFFF_F87A;
  localparam logic [31:0] UA = 32'hFFFF_FCB2;
  localparam logic [31:0] XA = 32'hFFFF_F000;

  logic clk = 0, rst_n = 0, wr_en = 0, wr_byte = 0, rd_en = 0;
  logic [31:0] addr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic mon_active, wr_reject;

  int checks = 0, errors = 0;
  bit m_en, m_st, m_arm;

  always #10 clk = ~clk;

  wprot_ctl i_wprot_ctl (.clk, .rst_n, .addr, .wr_en, .wr_byte, .wdata,
    .rd_en, .rdata, .mon_active, .wr_reject);

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(logic [31:0] a);
    if (a == PA) return {7'b0, m_en};
    if (a == SA) return {7'b0, m_st};
    return 8'h00;
  endfunction

  task automatic do_reset();
    rst_n = 0; wr_en = 0; rd_en = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    m_en = 0; m_st = 0; m_arm = 0;
    chk("R1 reject", {7'b0, wr_reject}, 8'h00);
    chk("R1 active", {7'b0, mon_active}, 8'h00);
  endtask

  task automatic wr(logic [31:0] a, logic [7:0] d, bit b, string req, bit rd = 0);
    bit rej;
    addr = a; wdata = d; wr_byte = b; wr_en = 1; rd_en = rd;
    if (rd) begin
      #1 chk({req, " R11 same-cycle read"}, rdata, exp_rd(a));
    end
    rej = (a == PA) && !m_arm;
    if (a == PA && m_arm && d[0]) m_en = 1;
    if (a == SA && m_en && d[0]) m_st = 1;
    m_arm = (a == UA) && b;
    @(negedge clk);
    wr_en = 0; rd_en = 0;
    chk({req, " R5 reject"}, {7'b0, wr_reject}, {7'b0, rej});
    chk({req, " R10 active"}, {7'b0, mon_active}, {7'b0, m_en & m_st});
  endtask

  task automatic rd(logic [31:0] a, string req);
    addr = a; rd_en = 1; wr_en = 0;
    #1 chk(req, rdata, exp_rd(a));
    @(negedge clk);
    rd_en = 0;
    #1 chk("R11 idle read", rdata, 8'h00);
  endtask

  initial begin
    #4_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    @(negedge clk);
    do_reset();
    rd(PA, "R1 prot");
    rd(SA, "R1 start");
    wr(PA, 8'hFF, 1, "R5 unarmed");
    rd(PA, "R5 unchanged");
    wr(SA, 8'h01, 1, "R9 start without enable");
    rd(SA, "R9 ignored");
    wr(UA, 8'h5A, 0, "R7 partial unlock");
    wr(PA, 8'h01, 1, "R7 still locked");
    wr(UA, 8'h00, 1, "R2 unlock");
    rd(UA, "R8 unlock reads zero");
    rd(PA, "R6 read keeps arm");
    wr(PA, 8'hFF, 1, "R2 protected write");
    rd(PA, "R4 upper bits zero");
    wr(PA, 8'h01, 1, "R6 second write blocked");
    wr(UA, 8'h33, 1, "R2 unlock");
    wr(PA, 8'h00, 1, "R3 write zero", 1);
    rd(PA, "R3 enable kept");
    wr(UA, 8'h11, 1, "R6 unlock");
    wr(XA, 8'h00, 1, "R6 other addr");
    wr(PA, 8'h01, 1, "R6 disarmed");
    wr(SA, 8'hFE, 1, "R9 bit0 clear");
    wr(SA, 8'hFF, 1, "R9 start");
    rd(SA, "R4 start upper zero");
    wr(SA, 8'h00, 1, "R10 stays");
    do_reset();
    rd(PA, "R1 after reset");
    for (int i = 0; i < 3000; i++) begin
      int k = $urandom_range(0, 9);
      logic [31:0] a = (k < 3) ? UA : (k < 6) ? PA : (k < 8) ? SA : XA;
      if ($urandom_range(0, 3) == 0) rd(a, "R11 random read");
      else wr(a, 8'($urandom), ($urandom_range(0, 4) != 0), "R6 random",
              ($urandom_range(0, 3) == 0));
      if ($urandom_range(0, 499) == 0) do_reset();
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule